// File: doc/BRIEF.md
# Clock Frequency Transition Sequencer

This block steps a processor clock domain from one performance level to another without software babysitting each register write. A request names the level the domain is leaving and the level it should reach. Six levels are supported, numbered 0 to 5 for 1400, 1200, 1000, 800, 500 and 200 MHz, so a smaller number is a faster clock. The sequencer then emits a series of register-style writes: two divider words, the PLL configuration word, the PLL lock-time value and the core clock source select. Between writes it waits on the status that the clock hardware reports back.

The order of the steps follows the direction of the change. When speeding up, the dividers move first and the PLL second. When slowing down, the PLL moves first and the dividers follow. If the two levels share the same PLL multiplier and pre-divider, only the 3-bit post-divider is rewritten. Otherwise the core is parked on a backup PLL while the main PLL is reprogrammed and relocks. Every wait is bounded by a programmable timeout. A request that cannot be honoured raises a sticky error.

Top module: `clk_transition_seq`

## Requirements
- R1: The PLL word places M at bits 25:16, P at bits 13:8 and S at bits 2:0, with all other bits zero. For levels 0..5, (M,P,S) is (350,6,1), (150,3,1), (250,6,1), (200,6,1), (250,6,2) and (200,6,3).
- R2: Divider word 0 holds seven 3-bit fields at bits 4k+2:4k for k = 0..6. It reads 0x07143730 for levels 0-2, 0x07133730 for levels 3-4 and 0x00131310 for level 5. Divider word 1 holds a copy divider at bits 6:4 and a monitor divider of 0 at bits 2:0. It reads 0x50, 0x50, 0x40, 0x30, 0x30 and 0x30 for levels 0..5.
- R3: When the new index is below the old index, both divider words are written before any PLL write.
- R4: When the new index is above the old index, the PLL update completes before divider word 0 is written.
- R5: A full PLL update runs in this order: set the source select to backup (coreMuxBackup=1), wait for muxStat = 2, write the lock time, write the whole PLL word, wait for pllLocked, set the select back to main, and wait for muxStat = 1.
- R6: When M and P match between the two levels, only the S field of the PLL word changes. The write happens on the main source, with no lock-time write and no source switch.
- R7: After divider word 0 is written, word 1 is not written until every bit of div0Stat under mask 0x1111111 is clear. After word 1, the transition does not finish until div1Stat under mask 0x11 is clear. Bits outside the masks are ignored.
- R8: A request with equal old and new index produces no writes and one done pulse.
- R9: A request is taken only while busy is low. busy is high from the cycle after acceptance until the done cycle. done is high for exactly one cycle per transition. A request presented while busy has no effect.
- R10: If a wait outlasts timeoutLimit cycles, errFlag is set and stays set until reset. busy drops without a done pulse, and no further write is issued.
- R11: A request is rejected if either index exceeds 5 or lies outside [maxLevel, minLevel]. A rejected request sets errFlag, issues no write, never raises busy and gives no done.
- R12: After reset, busy, done, errFlag, coreMuxBackup, every write strobe and lockTime are zero. The divider and PLL words hold the values of level INIT_LEVEL (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transition request strobe |
| reqOldIdx | input | 3 | Level being left |
| reqNewIdx | input | 3 | Level to reach |
| maxLevel | input | 3 | Fastest allowed level (smallest index) |
| minLevel | input | 3 | Slowest allowed level (largest index) |
| timeoutLimit | input | 16 | Wait timeout in cycles |
| div0Stat | input | 28 | Divider word 0 busy status, busy bits under mask 0x1111111 |
| div1Stat | input | 8 | Divider word 1 busy status, busy bits under mask 0x11 |
| muxStat | input | 3 | Core source status: 1 main, 2 backup |
| pllLocked | input | 1 | Main PLL locked flag |
| divWord0 | output | 32 | Divider word 0 |
| divWr0 | output | 1 | Write strobe for divWord0 |
| divWord1 | output | 8 | Divider word 1 |
| divWr1 | output | 1 | Write strobe for divWord1 |
| pllWord | output | 32 | PLL M/P/S word |
| pllWr | output | 1 | Write strobe for pllWord |
| lockTime | output | 16 | PLL lock-time value |
| lockWr | output | 1 | Write strobe for lockTime |
| coreMuxBackup | output | 1 | Core source select, 1 = backup PLL |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Sticky error (timeout or rejected request) |

## Verification
The assertions check several invariants on every cycle. done is never high two cycles in a row. errFlag never falls. busy only ends through done or an error. A full PLL write only happens while the core runs from the backup source, and an S-only write only happens on the main source. The lock-time write follows a backup status of 2, and divider word 1 is written only after the masked word-0 status has cleared. A rejected request never raises busy. Only the bench scenarios can show the rest: the exact order and values of writes for each direction and each kind of PLL change, that requests arriving mid-transition are ignored, and that the write stream stops after a timeout. The bench checks this against status models with random latencies and noise in the unmasked status bits.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
package clkseq_pkg;
  localparam int NUM_LEVELS  = 6;
  localparam int IDX_W       = 3;
  localparam int DIV0_FIELDS = 7;
  localparam int DIV1_FIELDS = 2;
  localparam int DIV0_STAT_W = 4 * DIV0_FIELDS;
  localparam int DIV1_STAT_W = 4 * DIV1_FIELDS;
  localparam logic [2:0] MUX_MAIN_CODE   = 3'd1;
  localparam logic [2:0] MUX_BACKUP_CODE = 3'd2;

  typedef struct packed {
    logic latchReq;
    logic wrDiv0;
    logic wrDiv1;
    logic wrSOnly;
    logic wrPllFull;
    logic wrLock;
    logic muxBackup;
    logic muxMain;
    logic tmrClr;
  } seqStrobe_t;

  function automatic logic [31:0] nibbleMask(input int n);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < n; k++) m[4*k] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] pllWordOf(input logic [IDX_W-1:0] idx);
    logic [9:0] m;
    logic [5:0] p;
    logic [2:0] s;
    case (idx)
      3'd0:    begin m = 10'd350; p = 6'd6; s = 3'd1; end
      3'd1:    begin m = 10'd150; p = 6'd3; s = 3'd1; end
      3'd2:    begin m = 10'd250; p = 6'd6; s = 3'd1; end
      3'd3:    begin m = 10'd200; p = 6'd6; s = 3'd1; end
      3'd4:    begin m = 10'd250; p = 6'd6; s = 3'd2; end
      default: begin m = 10'd200; p = 6'd6; s = 3'd3; end
    endcase
    return {6'd0, m, 2'd0, p, 5'd0, s};
  endfunction

  function automatic logic mpDiffers(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
    logic [31:0] wa, wb;
    wa = pllWordOf(a);
    wb = pllWordOf(b);
    return wa[25:8] != wb[25:8];
  endfunction

  function automatic logic [31:0] div0WordOf(input logic [IDX_W-1:0] idx);
    logic [3*DIV0_FIELDS-1:0] f;
    logic [31:0] w;
    // fields listed from k=6 down to k=0
    if (idx <= 3'd2)      f = {3'd7, 3'd1, 3'd4, 3'd3, 3'd7, 3'd3, 3'd0};
    else if (idx <= 3'd4) f = {3'd7, 3'd1, 3'd3, 3'd3, 3'd7, 3'd3, 3'd0};
    else                  f = {3'd0, 3'd1, 3'd3, 3'd1, 3'd3, 3'd1, 3'd0};
    w = '0;
    for (int k = 0; k < DIV0_FIELDS; k++) w[4*k +: 3] = f[3*k +: 3];
    return w;
  endfunction

  function automatic logic [7:0] div1WordOf(input logic [IDX_W-1:0] idx);
    logic [2:0] copyDiv;
    if (idx <= 3'd1)      copyDiv = 3'd5;
    else if (idx == 3'd2) copyDiv = 3'd4;
    else                  copyDiv = 3'd3;
    return {1'b0, copyDiv, 1'b0, 3'd0};
  endfunction
endpackage

// File: rtl/clkseq_datapath.sv
`timescale 1ns/1ps
module clkseq_datapath
  import clkseq_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int LOCK_W     = 16,
  parameter int INIT_LEVEL = 2,
  parameter int LOCK_TIME  = 270
)(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [IDX_W-1:0]    reqNewIdx,
  input  logic [TMR_W-1:0]    timeoutLimit,
  output logic                tmrExpired,
  output logic [31:0]         divWord0,
  output logic                divWr0,
  output logic [7:0]          divWord1,
  output logic                divWr1,
  output logic [31:0]         pllWord,
  output logic                pllWr,
  output logic [LOCK_W-1:0]   lockTime,
  output logic                lockWr,
  output logic                coreMuxBackup
);
  localparam logic [IDX_W-1:0] INIT_IDX = IDX_W'(INIT_LEVEL);

  logic [IDX_W-1:0] newIdxQ;
  logic [TMR_W-1:0] tmrCnt;
  logic [31:0]      tgtPll;

  assign tgtPll     = pllWordOf(newIdxQ);
  assign tmrExpired = tmrCnt >= timeoutLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newIdxQ       <= INIT_IDX;
      divWord0      <= div0WordOf(INIT_IDX);
      divWord1      <= div1WordOf(INIT_IDX);
      pllWord       <= pllWordOf(INIT_IDX);
      lockTime      <= '0;
      coreMuxBackup <= 1'b0;
      tmrCnt        <= '0;
      divWr0        <= 1'b0;
      divWr1        <= 1'b0;
      pllWr         <= 1'b0;
      lockWr        <= 1'b0;
    end else begin
      divWr0 <= stb.wrDiv0;
      divWr1 <= stb.wrDiv1;
      pllWr  <= stb.wrSOnly | stb.wrPllFull;
      lockWr <= stb.wrLock;
      if (stb.latchReq)  newIdxQ  <= reqNewIdx;
      if (stb.wrDiv0)    divWord0 <= div0WordOf(newIdxQ);
      if (stb.wrDiv1)    divWord1 <= div1WordOf(newIdxQ);
      if (stb.wrSOnly)   pllWord[2:0] <= tgtPll[2:0];
      if (stb.wrPllFull) pllWord  <= tgtPll;
      if (stb.wrLock)    lockTime <= LOCK_W'(LOCK_TIME);
      if (stb.muxBackup)    coreMuxBackup <= 1'b1;
      else if (stb.muxMain) coreMuxBackup <= 1'b0;
      if (stb.tmrClr)       tmrCnt <= '0;
      else if (!tmrExpired) tmrCnt <= tmrCnt + 1'b1;
    end
  end

  AST_FULL_ON_BACKUP: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrPllFull |-> coreMuxBackup) else $error("full PLL write off backup"); // R5
  AST_SONLY_ON_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSOnly |-> !coreMuxBackup) else $error("S-only write on backup"); // R6
  AST_SONLY_KEEPS_MP: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSOnly |=> $stable(pllWord[25:8])) else $error("S-only touched M/P"); // R6
endmodule

// File: rtl/clkseq_ctrl.sv
`timescale 1ns/1ps
module clkseq_ctrl
  import clkseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [IDX_W-1:0]       reqOldIdx,
  input  logic [IDX_W-1:0]       reqNewIdx,
  input  logic [IDX_W-1:0]       maxLevel,
  input  logic [IDX_W-1:0]       minLevel,
  input  logic [DIV0_STAT_W-1:0] div0Stat,
  input  logic [DIV1_STAT_W-1:0] div1Stat,
  input  logic [2:0]             muxStat,
  input  logic                   pllLocked,
  input  logic                   tmrExpired,
  output seqStrobe_t             stb,
  output logic                   busy,
  output logic                   done,
  output logic                   errFlag
);
  localparam logic [DIV0_STAT_W-1:0] DIV0_MASK = DIV0_STAT_W'(nibbleMask(DIV0_FIELDS));
  localparam logic [DIV1_STAT_W-1:0] DIV1_MASK = DIV1_STAT_W'(nibbleMask(DIV1_FIELDS));
  localparam logic [IDX_W-1:0]       TOP_IDX   = IDX_W'(NUM_LEVELS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DIV0_WR, S_DIV0_WAIT, S_DIV1_WR, S_DIV1_WAIT, S_SONLY_WR,
    S_MUX_BK, S_MUX_BK_WAIT, S_LOCK_WR, S_PMS_WR, S_LOCK_WAIT,
    S_MUX_MAIN, S_MUX_MAIN_WAIT, S_FINISH
  } seqState_t;

  seqState_t state, nextState;
  logic raiseQ, fullQ, setErr, reqOk, div0Clear, div1Clear;

  assign reqOk = (reqOldIdx <= TOP_IDX) && (reqNewIdx <= TOP_IDX) &&
                 (reqOldIdx >= maxLevel) && (reqOldIdx <= minLevel) &&
                 (reqNewIdx >= maxLevel) && (reqNewIdx <= minLevel);
  assign div0Clear = (div0Stat & DIV0_MASK) == '0;
  assign div1Clear = (div1Stat & DIV1_MASK) == '0;
  assign busy = state != S_IDLE;
  assign done = state == S_FINISH;

  always_comb begin
    nextState = state;
    setErr    = 1'b0;
    stb       = '0;
    case (state)
      S_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        if (!reqOk)                      setErr = 1'b1;
        else if (reqOldIdx == reqNewIdx) nextState = S_FINISH;
        else if (reqNewIdx < reqOldIdx)  nextState = S_DIV0_WR;
        else nextState = mpDiffers(reqOldIdx, reqNewIdx) ? S_MUX_BK : S_SONLY_WR;
      end
      S_DIV0_WR: begin stb.wrDiv0 = 1'b1; stb.tmrClr = 1'b1; nextState = S_DIV0_WAIT; end
      S_DIV0_WAIT:
        if (div0Clear)       nextState = S_DIV1_WR;
        else if (tmrExpired) begin setErr = 1'b1; nextState = S_IDLE; end
      S_DIV1_WR: begin stb.wrDiv1 = 1'b1; stb.tmrClr = 1'b1; nextState = S_DIV1_WAIT; end
      S_DIV1_WAIT:
        if (div1Clear)       nextState = !raiseQ ? S_FINISH : (fullQ ? S_MUX_BK : S_SONLY_WR);
        else if (tmrExpired) begin setErr = 1'b1; nextState = S_IDLE; end
      S_SONLY_WR: begin stb.wrSOnly = 1'b1; nextState = raiseQ ? S_FINISH : S_DIV0_WR; end
      S_MUX_BK: begin stb.muxBackup = 1'b1; stb.tmrClr = 1'b1; nextState = S_MUX_BK_WAIT; end
      S_MUX_BK_WAIT:
        if (muxStat == MUX_BACKUP_CODE) nextState = S_LOCK_WR;
        else if (tmrExpired)            begin setErr = 1'b1; nextState = S_IDLE; end
      S_LOCK_WR: begin stb.wrLock = 1'b1; nextState = S_PMS_WR; end
      S_PMS_WR: begin stb.wrPllFull = 1'b1; stb.tmrClr = 1'b1; nextState = S_LOCK_WAIT; end
      S_LOCK_WAIT:
        if (pllLocked)       nextState = S_MUX_MAIN;
        else if (tmrExpired) begin setErr = 1'b1; nextState = S_IDLE; end
      S_MUX_MAIN: begin stb.muxMain = 1'b1; stb.tmrClr = 1'b1; nextState = S_MUX_MAIN_WAIT; end
      S_MUX_MAIN_WAIT:
        if (muxStat == MUX_MAIN_CODE) nextState = raiseQ ? S_FINISH : S_DIV0_WR;
        else if (tmrExpired)          begin setErr = 1'b1; nextState = S_IDLE; end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      raiseQ  <= 1'b0;
      fullQ   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (setErr) errFlag <= 1'b1;
      if (state == S_IDLE && reqValid && reqOk) begin
        raiseQ <= reqNewIdx < reqOldIdx;
        fullQ  <= mpDiffers(reqOldIdx, reqNewIdx);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag) else $error("error flag cleared"); // R10
  AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(done) || errFlag)) else $error("busy ended without done or error"); // R10
  AST_DIV1_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDiv1 |-> $past((div0Stat & DIV0_MASK) == '0)) else $error("word 1 before word 0 settled"); // R7
  AST_LOCK_ON_BACKUP: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrLock |-> $past(muxStat) == MUX_BACKUP_CODE) else $error("lock write before backup"); // R5
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !reqOk) |=> !busy) else $error("rejected request started"); // R11
endmodule

// File: rtl/clk_transition_seq.sv
`timescale 1ns/1ps
module clk_transition_seq
  import clkseq_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int LOCK_W     = 16,
  parameter int INIT_LEVEL = 2,
  parameter int LOCK_TIME  = 270
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [IDX_W-1:0]       reqOldIdx,
  input  logic [IDX_W-1:0]       reqNewIdx,
  input  logic [IDX_W-1:0]       maxLevel,
  input  logic [IDX_W-1:0]       minLevel,
  input  logic [TMR_W-1:0]       timeoutLimit,
  input  logic [DIV0_STAT_W-1:0] div0Stat,
  input  logic [DIV1_STAT_W-1:0] div1Stat,
  input  logic [2:0]             muxStat,
  input  logic                   pllLocked,
  output logic [31:0]            divWord0,
  output logic                   divWr0,
  output logic [7:0]             divWord1,
  output logic                   divWr1,
  output logic [31:0]            pllWord,
  output logic                   pllWr,
  output logic [LOCK_W-1:0]      lockTime,
  output logic                   lockWr,
  output logic                   coreMuxBackup,
  output logic                   busy,
  output logic                   done,
  output logic                   errFlag
);
  seqStrobe_t stb;
  logic       tmrExpired;

  clkseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOldIdx(reqOldIdx),
    .reqNewIdx(reqNewIdx), .maxLevel(maxLevel), .minLevel(minLevel),
    .div0Stat(div0Stat), .div1Stat(div1Stat), .muxStat(muxStat),
    .pllLocked(pllLocked), .tmrExpired(tmrExpired), .stb(stb),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  clkseq_datapath #(
    .TMR_W(TMR_W), .LOCK_W(LOCK_W), .INIT_LEVEL(INIT_LEVEL), .LOCK_TIME(LOCK_TIME)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqNewIdx(reqNewIdx),
    .timeoutLimit(timeoutLimit), .tmrExpired(tmrExpired),
    .divWord0(divWord0), .divWr0(divWr0), .divWord1(divWord1), .divWr1(divWr1),
    .pllWord(pllWord), .pllWr(pllWr), .lockTime(lockTime), .lockWr(lockWr),
    .coreMuxBackup(coreMuxBackup)
  );
endmodule

// File: tb/clk_transition_seq_tb.sv
`timescale 1ns/1ps
module clk_transition_seq_tb;
  localparam int LOCKV = 270;
  // event codes: 1 div0, 2 div1, 3 pll S-only, 4 pll full, 5 to backup, 6 to main, 7 lock time
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, reqValid, pllLocked;
  logic [2:0] reqOldIdx, reqNewIdx, maxLevel, minLevel, muxStat;
  logic [15:0] timeoutLimit;
  logic [27:0] div0Stat;
  logic [7:0]  div1Stat;
  logic [31:0] divWord0, pllWord;
  logic [7:0]  divWord1;
  logic [15:0] lockTime;
  logic divWr0, divWr1, pllWr, lockWr, coreMuxBackup, busy, done, errFlag;

  clk_transition_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOldIdx(reqOldIdx),
    .reqNewIdx(reqNewIdx), .maxLevel(maxLevel), .minLevel(minLevel),
    .timeoutLimit(timeoutLimit), .div0Stat(div0Stat), .div1Stat(div1Stat),
    .muxStat(muxStat), .pllLocked(pllLocked), .divWord0(divWord0), .divWr0(divWr0),
    .divWord1(divWord1), .divWr1(divWr1), .pllWord(pllWord), .pllWr(pllWr),
    .lockTime(lockTime), .lockWr(lockWr), .coreMuxBackup(coreMuxBackup),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  int tests = 0, fails = 0;
  int cur = 2;

  // ---------------- status models ----------------
  int dly = 3;
  bit hangDiv = 0, hangLock = 0;
  int d0Cnt, d1Cnt, muxCnt, lkCnt;
  logic muxCur;
  logic [27:0] noise0;
  logic [7:0]  noise1;
  always @(posedge clk) begin
    if (!rstN) begin
      d0Cnt <= 0; d1Cnt <= 0; muxCnt <= 0; lkCnt <= 0; muxCur <= 1'b0;
    end else begin
      if (divWr0) d0Cnt <= dly; else if (d0Cnt != 0 && !hangDiv) d0Cnt <= d0Cnt - 1;
      if (divWr1) d1Cnt <= dly; else if (d1Cnt != 0) d1Cnt <= d1Cnt - 1;
      if (coreMuxBackup != muxCur) begin
        if (muxCnt >= dly) begin muxCur <= coreMuxBackup; muxCnt <= 0; end
        else muxCnt <= muxCnt + 1;
      end
      if (pllWr && coreMuxBackup) lkCnt <= dly;
      else if (lkCnt != 0 && !hangLock) lkCnt <= lkCnt - 1;
      noise0 <= 28'($urandom) & ~28'h1111111;
      noise1 <= 8'($urandom) & ~8'h11;
    end
  end
  assign div0Stat  = (divWr0 || d0Cnt != 0) ? (28'h1111111 | noise0) : noise0;
  assign div1Stat  = (divWr1 || d1Cnt != 0) ? (8'h11 | noise1) : noise1;
  assign muxStat   = (coreMuxBackup != muxCur) ? 3'd0 : (muxCur ? 3'd2 : 3'd1);
  assign pllLocked = !((pllWr && coreMuxBackup) || lkCnt != 0);

  // ---------------- expected tables ----------------
  function automatic logic [31:0] expPll(int i);
    case (i)
      0: return 32'h015E0601; 1: return 32'h00960301; 2: return 32'h00FA0601;
      3: return 32'h00C80601; 4: return 32'h00FA0602; default: return 32'h00C80603;
    endcase
  endfunction
  function automatic logic [31:0] expDiv0(int i);
    if (i <= 2) return 32'h07143730;
    if (i <= 4) return 32'h07133730;
    return 32'h00131310;
  endfunction
  function automatic logic [31:0] expDiv1(int i);
    if (i <= 1) return 32'h50;
    if (i == 2) return 32'h40;
    return 32'h30;
  endfunction

  // ---------------- event log ----------------
  int evCode[32]; logic [31:0] evVal[32]; int evCnt = 0;
  int exCode[32]; logic [31:0] exVal[32]; int exCnt = 0;
  int doneCnt = 0; bit busySeen = 0; logic prevMux = 1'b0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic logEv(int c, logic [31:0] v);
    if (evCnt < 32) begin evCode[evCnt] = c; evVal[evCnt] = v; end
    evCnt++;
  endtask

  always @(negedge clk) if (rstN) begin
    if (divWr0) logEv(1, divWord0);
    if (divWr1) begin
      logEv(2, 32'(divWord1));
      check((div0Stat & 28'h1111111) == 0, "R7 word1 after word0 clear", 32'(div0Stat), 0);
    end
    if (pllWr) logEv(coreMuxBackup ? 4 : 3, pllWord);
    if (lockWr) begin
      logEv(7, 32'(lockTime));
      check(muxStat == 3'd2, "R5 lock write on backup status", 32'(muxStat), 2);
    end
    if (coreMuxBackup != prevMux) begin
      logEv(coreMuxBackup ? 5 : 6, 0);
      if (!coreMuxBackup) check(pllLocked, "R5 return to main after lock", 32'(pllLocked), 1);
    end
    prevMux = coreMuxBackup;
    if (busy) busySeen = 1;
    if (done) begin
      doneCnt++;
      check(muxStat == 3'd1 && (div1Stat & 8'h11) == 0, "R7 R5 settled at done",
            {29'd0, muxStat}, 1);
    end
  end

  task automatic pushExp(int c, logic [31:0] v);
    exCode[exCnt] = c; exVal[exCnt] = v; exCnt++;
  endtask

  task automatic buildExp(int o, int n);
    bit full;
    exCnt = 0;
    if (o == n) return;
    full = expPll(o) >> 8 != expPll(n) >> 8;
    if (n < o) begin pushExp(1, expDiv0(n)); pushExp(2, expDiv1(n)); end
    if (full) begin
      pushExp(5, 0); pushExp(7, LOCKV); pushExp(4, expPll(n)); pushExp(6, 0);
    end else pushExp(3, expPll(n));
    if (n > o) begin pushExp(1, expDiv0(n)); pushExp(2, expDiv1(n)); end
  endtask

  task automatic clearLog();
    evCnt = 0; doneCnt = 0; busySeen = 0;
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; prevMux = 1'b0; cur = 2;
    @(negedge clk);
  endtask

  task automatic compareSeq(string tag);
    bit ok;
    ok = (evCnt == exCnt);
    for (int i = 0; i < exCnt && ok; i++)
      if (evCode[i] != exCode[i] || evVal[i] != exVal[i]) ok = 0;
    check(ok, tag, 32'(evCnt), 32'(exCnt));
  endtask

  task automatic runTxn(int o, int n, string tag, bit poke = 0);
    int waitN;
    buildExp(o, n);
    clearLog();
    @(negedge clk);
    reqValid = 1'b1; reqOldIdx = 3'(o); reqNewIdx = 3'(n);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy, "R9 busy after acceptance", 32'(busy), 1);
    if (poke) begin
      repeat (2) @(negedge clk);
      reqValid = 1'b1; reqOldIdx = 3'(n); reqNewIdx = 3'(o);
      @(negedge clk);
      reqValid = 1'b0;
    end
    waitN = 0;
    while (doneCnt == 0 && !errFlag && waitN < 3000) begin @(negedge clk); waitN++; end
    repeat (3) @(negedge clk);
    check(doneCnt == 1 && !busy && !errFlag, {tag, " R9 one done"}, 32'(doneCnt), 1);
    compareSeq({tag, " R1 R2 sequence"});
    cur = n;
  endtask

  task automatic rejTxn(int o, int n);
    doReset();
    clearLog();
    reqValid = 1'b1; reqOldIdx = 3'(o); reqNewIdx = 3'(n);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    check(errFlag && !busySeen && evCnt == 0 && doneCnt == 0, "R11 rejected request",
          {30'd0, errFlag, busySeen}, 2);
    check(pllWord == expPll(2), "R11 PLL word untouched", pllWord, expPll(2));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'd20240611));
    reqOldIdx = 0; reqNewIdx = 0; maxLevel = 3'd0; minLevel = 3'd5; timeoutLimit = 16'd200;
    doReset();
    // R12 reset state
    check(!busy && !done && !errFlag && !coreMuxBackup, "R12 reset flags",
          {28'd0, busy, done, errFlag, coreMuxBackup}, 0);
    check(divWord0 == expDiv0(2) && divWord1 == 8'h40, "R12 divider words", divWord0, expDiv0(2));
    check(pllWord == expPll(2) && lockTime == 0, "R12 PLL word", pllWord, expPll(2));
    check(!divWr0 && !divWr1 && !pllWr && !lockWr, "R12 strobes idle",
          {28'd0, divWr0, divWr1, pllWr, lockWr}, 0);

    runTxn(2, 4, "R4 R6 lower S-only");
    runTxn(4, 2, "R3 R6 raise S-only");
    runTxn(2, 2, "R8 equal index");
    runTxn(2, 0, "R3 R5 raise full");
    runTxn(0, 3, "R4 R5 lower full");
    runTxn(3, 5, "R6 lower S-only");
    runTxn(5, 3, "R6 raise S-only");
    dly = 8;
    runTxn(3, 1, "R9 request while busy ignored", 1);
    runTxn(1, 5, "R4 R5 lower full slow");

    for (int i = 0; i < 40; i++) begin
      int nw;
      nw = int'($urandom % 6);
      dly = 1 + int'($urandom % 12);
      runTxn(cur, nw, "R3 R4 random");
    end

    maxLevel = 3'd1; minLevel = 3'd4;
    rejTxn(2, 0);
    rejTxn(2, 5);
    rejTxn(5, 3);
    maxLevel = 3'd0; minLevel = 3'd5;
    rejTxn(6, 2);
    rejTxn(2, 7);

    // R10 timeout in divider wait
    doReset();
    timeoutLimit = 16'd30; dly = 3; hangDiv = 1;
    clearLog();
    reqValid = 1'b1; reqOldIdx = 3'd2; reqNewIdx = 3'd0;
    @(negedge clk); reqValid = 1'b0;
    repeat (150) @(negedge clk);
    check(errFlag && !busy && doneCnt == 0 && evCnt == 1, "R10 divider timeout",
          32'(evCnt), 1);
    hangDiv = 0;
    repeat (20) @(negedge clk);
    check(errFlag && evCnt == 1, "R10 error sticky no writes", {31'd0, errFlag}, 1);

    // R10 timeout in lock wait
    doReset();
    hangLock = 1;
    clearLog();
    reqValid = 1'b1; reqOldIdx = 3'd2; reqNewIdx = 3'd5;
    @(negedge clk); reqValid = 1'b0;
    repeat (150) @(negedge clk);
    check(errFlag && !busy && doneCnt == 0 && evCnt == 3 && coreMuxBackup, "R10 lock timeout",
          32'(evCnt), 3);
    hangLock = 0;
    doReset();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule